// File: doc/BRIEF.md
# Fault Aggregator with Status Readback

This block gathers fault indications from a multi-channel analog output device and combines them into one shared, active-low fault line. The line is modelled as an output enable: when the enable is high, the pad is pulled low. Several devices can then share one pull-up and one wired fault net. The fault sources are:

- a compliance fault per current output;
- a short-circuit fault per voltage output;
- an over-temperature flag;
- a check-code error pulse from the serial interface.

A 16-bit status word records which source is active, so the host can find out what caused the fault line.

The serial side works in 24-bit frames. A frame is bounded by a frame-select input and advanced by a bit strobe, and all of it is clocked by the system clock. A control bit, the status-echo mode, selects what the data-out line returns:

- **Echo mode on:** every frame returns the live status word in the same frame as the incoming write. Ordinary register reads are refused.
- **Echo mode off:** a read frame names a register, and that register is returned in the following frame.

To read another register, the host clears the echo bit, performs the read, and may then set the bit again.

Top module: `fsu_top`

## Requirements
- R1: After reset the fault enable and the data-out line are 0, echo mode is off, and a frame with no pending read returns all zeros.
- R2: The fault enable is 1 exactly when at least one of status bits 9:0 is 1.
- R3: A change on a per-channel or over-temperature fault input appears in the status word and on the fault enable after the third rising clock edge (two-flop synchronizer plus the status register).
- R4: Status layout for four channels: bits 3:0 are voltage-output short-circuit faults for channels 3..0, bits 7:4 are current-compliance faults for channels 3..0, bit 8 is the check-code error and bit 9 is over-temperature. Bits 15:10 read as 0.
- R5: A one-cycle check-code error pulse sets status bit 8 on the next edge. The bit stays set until a frame completes whose returned word showed it set, and it clears at the end of that frame. Hardware fault bits follow their synchronized inputs.
- R6: A frame is exactly 24 strobes while the select input is high, most significant bit first. Bit 23 is 1 for read and 0 for write, bits 19:16 are the address and bits 15:0 are the data. A frame with any other strobe count is discarded. A write to address 0 sets echo mode from data bit 0 when the select input falls.
- R7: With echo mode on, every frame shifts out {8'h00, status}. The status is taken on the clock edge where the frame starts, and each bit is on data-out before the strobe that advances it.
- R8: With echo mode off, a read frame of address A makes the next frame return {8'h00, value}. Address 0 gives {15'b0, echo bit}, address 1 gives status and any other address gives 0. The pending read is consumed by that next frame.
- R9: With echo mode on, read frames leave no read pending. After echo mode is cleared a read works normally, and echo mode can then be set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vflt_i | input | NCH | Voltage-output short-circuit fault per channel (asynchronous) |
| iflt_i | input | NCH | Current-output compliance fault per channel (asynchronous) |
| otemp_i | input | 1 | Over-temperature flag (asynchronous) |
| pec_err_i | input | 1 | One-cycle check-code error pulse from the interface (synchronous) |
| cs_i | input | 1 | Frame select, high for the length of a frame (synchronous) |
| sck_en_i | input | 1 | Bit strobe, one per serial bit (synchronous) |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| fault_oe_o | output | 1 | Pull-down enable for the shared active-low fault line |

## Verification
The timing of each result is fixed as follows:

- A level change on a hardware fault input reaches status and the fault enable after the third rising edge.
- A check-code pulse reaches status one edge later.
- A control write takes effect on the edge where the select input falls.
- A returned bit is valid on data-out before the strobe that consumes it.

The bench keeps a behavioural model that is stepped on the same rising edge as the design, using an input history queue for the synchronizer delay. It compares the fault enable and data-out on every falling edge, away from the edges where either side updates. Directed checks capture each returned bit on the falling edge before its strobe. They also sample the fault enable on the second and third falling edges after an input change, to pin down the three-edge latency.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

    localparam int FRAME_BITS = 24;
    localparam int WORD_BITS  = 16;
    localparam int ADDR_BITS  = 4;
    localparam int CNT_BITS   = $clog2(FRAME_BITS + 1) + 1;
    localparam int PAD_BITS   = FRAME_BITS - WORD_BITS - ADDR_BITS - 1;

    localparam logic [ADDR_BITS-1:0] ADDR_CTRL = 4'd0;
    localparam logic [ADDR_BITS-1:0] ADDR_STAT = 4'd1;

    // Layout of one serial frame, first bit shifted is the MSB.
    typedef struct packed {
        logic                 rd;
        logic [PAD_BITS-1:0]  pad;
        logic [ADDR_BITS-1:0] addr;
        logic [WORD_BITS-1:0] data;
    } frame_t;

    // What the outgoing shift register was loaded with at frame start.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_STATUS = 2'd1,
        SRC_REG    = 2'd2
    } out_src_e;

    // Decoded result of a completed, well-formed frame.
    typedef struct packed {
        logic                 wr_ctrl;
        logic                 ctrl_bit;
        logic                 rd_req;
        logic [ADDR_BITS-1:0] rd_addr;
    } cmd_t;

    function automatic logic [FRAME_BITS-1:0] pad_word(input logic [WORD_BITS-1:0] w);
        return {{(FRAME_BITS - WORD_BITS){1'b0}}, w};
    endfunction

    function automatic int pec_pos(input int nch);
        return 2 * nch;
    endfunction

endpackage

// File: rtl/fsu_sync.sv
module fsu_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;

endmodule

// File: rtl/fsu_status.sv
module fsu_status
    import fsu_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       vout_flt_i,
    input  logic [NCH-1:0]       iout_flt_i,
    input  logic                 ot_i,
    input  logic                 pec_err_i,
    input  logic                 pec_clr_i,
    output logic [WORD_BITS-1:0] status_o,
    output logic                 fault_oe_o
);

    localparam int USED_BITS = 2 * NCH + 2;

    logic [NCH-1:0] vout_q;
    logic [NCH-1:0] iout_q;
    logic           ot_q;
    logic           pec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vout_q <= '0;
            iout_q <= '0;
            ot_q   <= 1'b0;
            pec_q  <= 1'b0;
        end else begin
            vout_q <= vout_flt_i;
            iout_q <= iout_flt_i;
            ot_q   <= ot_i;
            // a new error wins over an acknowledge in the same cycle
            pec_q  <= pec_err_i | (pec_q & ~pec_clr_i);
        end
    end

    logic [USED_BITS-1:0] used_bits;
    assign used_bits = {ot_q, pec_q, iout_q, vout_q};
    assign status_o  = WORD_BITS'(used_bits);

    // one pull-down request for any recorded cause
    assign fault_oe_o = |used_bits;

endmodule

// File: rtl/fsu_frame.sv
module fsu_frame
    import fsu_pkg::*;
#(
    parameter int PEC_BIT = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_i,
    input  logic                 sck_en_i,
    input  logic                 sdi_i,
    input  logic                 echo_en_i,
    input  logic [WORD_BITS-1:0] status_i,
    input  logic [WORD_BITS-1:0] reg_word_i,
    output logic                 sdo_o,
    output logic [ADDR_BITS-1:0] rd_addr_o,
    output logic                 rd_pend_o,
    output cmd_t                 cmd_o,
    output logic                 pec_ack_o
);

    localparam logic [CNT_BITS-1:0] FULL_CNT = CNT_BITS'(FRAME_BITS);

    logic                  cs_q;
    logic [CNT_BITS-1:0]   cnt_q;
    logic [FRAME_BITS-1:0] rx_q;
    logic [FRAME_BITS-1:0] tx_q;
    out_src_e              src_q;
    logic                  snap_pec_q;
    logic                  pend_q;
    logic [ADDR_BITS-1:0]  paddr_q;

    logic   start;
    logic   finish;
    logic   tick;
    logic   frame_ok;
    frame_t rx;

    assign start    = cs_i & ~cs_q;
    assign finish   = ~cs_i & cs_q;
    assign tick     = cs_i & cs_q & sck_en_i;
    assign rx       = frame_t'(rx_q);
    assign frame_ok = finish && (cnt_q == FULL_CNT);

    // choose what the next frame returns
    out_src_e             src_d;
    logic [WORD_BITS-1:0] load_word;

    always_comb begin
        if (echo_en_i) begin
            src_d = SRC_STATUS;
        end else if (pend_q) begin
            src_d = (paddr_q == ADDR_STAT) ? SRC_STATUS : SRC_REG;
        end else begin
            src_d = SRC_NONE;
        end
        unique case (src_d)
            SRC_STATUS: load_word = status_i;
            SRC_REG:    load_word = reg_word_i;
            default:    load_word = '0;
        endcase
    end

    always_comb begin
        cmd_o          = '0;
        cmd_o.wr_ctrl  = frame_ok & ~rx.rd & (rx.addr == ADDR_CTRL);
        cmd_o.ctrl_bit = rx.data[0];
        cmd_o.rd_req   = frame_ok & rx.rd & ~echo_en_i;
        cmd_o.rd_addr  = rx.addr;
    end

    // reserved frame bits and the upper control data carry no function
    logic unused_rx_bits;
    assign unused_rx_bits = ^{rx.pad, rx.data[WORD_BITS-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q       <= 1'b0;
            cnt_q      <= '0;
            rx_q       <= '0;
            tx_q       <= '0;
            src_q      <= SRC_NONE;
            snap_pec_q <= 1'b0;
            pend_q     <= 1'b0;
            paddr_q    <= '0;
        end else begin
            cs_q <= cs_i;
            if (start) begin
                tx_q       <= pad_word(load_word);
                src_q      <= src_d;
                snap_pec_q <= (src_d == SRC_STATUS) & load_word[PEC_BIT];
                pend_q     <= 1'b0;
                cnt_q      <= '0;
                rx_q       <= '0;
            end else if (tick) begin
                rx_q <= {rx_q[FRAME_BITS-2:0], sdi_i};
                tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
                if (cnt_q != '1) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (cmd_o.rd_req) begin
                pend_q  <= 1'b1;
                paddr_q <= cmd_o.rd_addr;
            end
        end
    end

    assign sdo_o     = tx_q[FRAME_BITS-1];
    assign rd_addr_o = paddr_q;
    assign rd_pend_o = pend_q;
    assign pec_ack_o = frame_ok & (src_q == SRC_STATUS) & snap_pec_q;

endmodule

// File: rtl/fsu_top.sv
module fsu_top
    import fsu_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] vflt_i,
    input  logic [NCH-1:0] iflt_i,
    input  logic           otemp_i,
    input  logic           pec_err_i,
    input  logic           cs_i,
    input  logic           sck_en_i,
    input  logic           sdi_i,
    output logic           sdo_o,
    output logic           fault_oe_o
);

    localparam int HW_W    = 2 * NCH + 1;
    localparam int PEC_BIT = pec_pos(NCH);

    logic [HW_W-1:0]      hw_raw;
    logic [HW_W-1:0]      hw_sync;
    logic [WORD_BITS-1:0] status_w;
    logic [WORD_BITS-1:0] reg_word;
    logic [ADDR_BITS-1:0] rd_addr_w;
    logic                 rd_pend_w;
    logic                 pec_ack_w;
    cmd_t                 cmd_w;
    logic                 echo_en_q;

    assign hw_raw = {otemp_i, iflt_i, vflt_i};

    fsu_sync #(.W(HW_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (hw_raw),
        .q_o (hw_sync)
    );

    fsu_status #(.NCH(NCH)) u_status (
        .clk        (clk),
        .rst        (rst),
        .vout_flt_i (hw_sync[NCH-1:0]),
        .iout_flt_i (hw_sync[2*NCH-1:NCH]),
        .ot_i       (hw_sync[2*NCH]),
        .pec_err_i  (pec_err_i),
        .pec_clr_i  (pec_ack_w),
        .status_o   (status_w),
        .fault_oe_o (fault_oe_o)
    );

    fsu_frame #(.PEC_BIT(PEC_BIT)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .cs_i       (cs_i),
        .sck_en_i   (sck_en_i),
        .sdi_i      (sdi_i),
        .echo_en_i  (echo_en_q),
        .status_i   (status_w),
        .reg_word_i (reg_word),
        .sdo_o      (sdo_o),
        .rd_addr_o  (rd_addr_w),
        .rd_pend_o  (rd_pend_w),
        .cmd_o      (cmd_w),
        .pec_ack_o  (pec_ack_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            echo_en_q <= 1'b0;
        end else if (cmd_w.wr_ctrl) begin
            echo_en_q <= cmd_w.ctrl_bit;
        end
    end

    always_comb begin
        unique case (rd_addr_w)
            ADDR_CTRL: reg_word = {{(WORD_BITS - 1){1'b0}}, echo_en_q};
            ADDR_STAT: reg_word = status_w;
            default:   reg_word = '0;
        endcase
    end

endmodule

// File: rtl/fsu_checker.sv
module fsu_checker
    import fsu_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NCH-1:0]       vflt,
    input logic                 pec_err,
    input logic                 fault_oe,
    input logic [WORD_BITS-1:0] status,
    input logic                 echo_en,
    input logic                 rd_pend,
    input logic                 pec_ack
);

    localparam int PEC_BIT = pec_pos(NCH);

    logic [2:0] cyc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
        end else if (cyc_q != 3'd7) begin
            cyc_q <= cyc_q + 3'd1;
        end
    end

    AST_PEC_RAISES_FAULT: assert property (@(posedge clk) disable iff (rst)
        pec_err |=> (fault_oe && status[PEC_BIT])); // R5

    AST_PEC_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (status[PEC_BIT] && !pec_ack && !rst) |=> status[PEC_BIT]); // R5

    AST_HW_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 3'd4) |-> (status[NCH-1:0] == $past(vflt, 3))); // R3

    AST_ECHO_OFF_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !echo_en); // R1

    AST_NO_READ_PENDING_IN_ECHO: assert property (@(posedge clk) disable iff (rst)
        echo_en |-> !rd_pend); // R9

endmodule

bind fsu_top fsu_checker #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .vflt     (vflt_i),
    .pec_err  (pec_err_i),
    .fault_oe (fault_oe_o),
    .status   (status_w),
    .echo_en  (echo_en_q),
    .rd_pend  (rd_pend_w),
    .pec_ack  (pec_ack_w)
);

// File: tb/fsu_top_tb_top.sv
`timescale 1ns/1ps
module fsu_top_tb_top;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] vflt = '0;
    logic [NCH-1:0] iflt = '0;
    logic           otemp = 1'b0;
    logic           pec = 1'b0;
    logic           cs = 1'b0;
    logic           sck = 1'b0;
    logic           sdi = 1'b0;
    logic           sdo;
    logic           fault_oe;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fsu_top #(.NCH(NCH)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .vflt_i     (vflt),
        .iflt_i     (iflt),
        .otemp_i    (otemp),
        .pec_err_i  (pec),
        .cs_i       (cs),
        .sck_en_i   (sck),
        .sdi_i      (sdi),
        .sdo_o      (sdo),
        .fault_oe_o (fault_oe)
    );

    // ---------------- behavioural reference model ----------------
    logic [8:0]  hist[$];
    logic [8:0]  m_hw = '0;
    logic        m_pec = 1'b0;
    logic        m_en = 1'b0;
    logic        m_csq = 1'b0;
    int          m_cnt = 0;
    logic [23:0] m_in = '0;
    logic [23:0] m_out = '0;
    logic        m_outstat = 1'b0;
    logic        m_snappec = 1'b0;
    logic        m_pend = 1'b0;
    logic [3:0]  m_paddr = '0;

    function automatic logic [15:0] m_status();
        return {6'b0, m_hw[8], m_pec, m_hw[7:0]};
    endfunction

    function automatic logic [15:0] m_reg(input logic [3:0] a);
        if (a == 4'd0) return {15'b0, m_en};
        if (a == 4'd1) return m_status();
        return 16'h0000;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            m_hw = '0; m_pec = 1'b0; m_en = 1'b0; m_csq = 1'b0; m_cnt = 0;
            m_in = '0; m_out = '0; m_outstat = 1'b0; m_snappec = 1'b0;
            m_pend = 1'b0; m_paddr = '0;
        end else begin
            logic [15:0] st;
            logic        clr;
            logic        en_n;
            st   = m_status();
            clr  = 1'b0;
            en_n = m_en;
            if (cs && !m_csq) begin
                if (m_en) begin
                    m_out = {8'h00, st}; m_outstat = 1'b1;
                end else if (m_pend) begin
                    m_out = {8'h00, m_reg(m_paddr)}; m_outstat = (m_paddr == 4'd1);
                end else begin
                    m_out = '0; m_outstat = 1'b0;
                end
                m_snappec = m_outstat && m_out[8];
                m_pend = 1'b0;
                m_cnt = 0;
                m_in = '0;
            end else if (cs && m_csq && sck) begin
                m_in  = {m_in[22:0], sdi};
                m_out = {m_out[22:0], 1'b0};
                if (m_cnt < 63) m_cnt++;
            end else if (!cs && m_csq && m_cnt == 24) begin
                if (!m_in[23] && m_in[19:16] == 4'd0) en_n = m_in[0];
                if (m_in[23] && !m_en) begin
                    m_pend = 1'b1; m_paddr = m_in[19:16];
                end
                clr = m_snappec;
            end
            m_en  = en_n;
            m_pec = pec | (m_pec & !clr);
            hist.push_front({otemp, iflt, vflt});
            if (hist.size() > 3) void'(hist.pop_back());
            m_hw  = (hist.size() == 3) ? hist[2] : '0;
            m_csq = cs;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (chk_on && !done) begin
            checks++;
            if (fault_oe !== (|m_status())) begin
                errors++;
                $display("FAIL R2 fault_oe got %0b exp %0b at %0t", fault_oe, |m_status(), $time);
            end
            checks++;
            if (sdo !== m_out[23]) begin
                errors++;
                $display("FAIL R6 sdo got %0b exp %0b at %0t", sdo, m_out[23], $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %06h exp %06h", tag, got, exp);
        end
    endtask

    function automatic logic [23:0] fw(input logic rd, input logic [3:0] a, input logic [15:0] d);
        return {rd, 3'b000, a, d};
    endfunction

    task automatic frame(input logic [23:0] w, input int nbits, output logic [23:0] got);
        got = '0;
        @(negedge clk); cs = 1'b1;
        @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            if (i < 24) got[23 - i] = sdo;
            sdi = w[23 - i];
            sck = 1'b1;
            @(negedge clk);
            sck = 1'b0;
        end
        @(negedge clk); cs = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [23:0] r;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        chk_on = 1'b1;
        @(negedge clk);
        chk("R1 fault after reset", {23'b0, fault_oe}, 24'h0);
        chk("R1 sdo after reset", {23'b0, sdo}, 24'h0);
        frame(fw(0, 4'd3, 16'h1234), 24, r);
        chk("R1 no pending read returns zero", r, 24'h0);

        // R3: three-edge latency from a fault input
        vflt = 4'b0100;
        wait_cyc(2);
        chk("R3 fault not yet after two edges", {23'b0, fault_oe}, 24'h0);
        wait_cyc(1);
        chk("R3 fault after third edge", {23'b0, fault_oe}, 24'h1);

        // R7: echo mode on
        frame(fw(0, 4'd0, 16'h0001), 24, r);
        chk("R7 enabling frame still mode off", r, 24'h0);
        frame(fw(0, 4'd5, 16'h0000), 24, r);
        chk("R7 R4 echo returns voltage fault bit 2", r, 24'h000004);

        iflt = 4'b0010; otemp = 1'b1;
        wait_cyc(4);
        frame(fw(0, 4'd5, 16'hFFFF), 24, r);
        chk("R4 layout current bit 5 over-temp bit 9", r, 24'h000224);

        vflt = '0; iflt = '0; otemp = 1'b0;
        wait_cyc(4);
        chk("R2 fault released when all clear", {23'b0, fault_oe}, 24'h0);

        // R5: sticky check-code error
        pec = 1'b1;
        @(negedge clk); pec = 1'b0;
        chk("R5 pulse sets fault", {23'b0, fault_oe}, 24'h1);
        wait_cyc(10);
        chk("R5 bit stays set", {23'b0, fault_oe}, 24'h1);
        frame(fw(0, 4'd5, 16'h0000), 24, r);
        chk("R5 R4 status read shows bit 8", r, 24'h000100);
        chk("R5 cleared after status read", {23'b0, fault_oe}, 24'h0);
        frame(fw(0, 4'd5, 16'h0000), 24, r);
        chk("R5 next status read clear", r, 24'h0);

        // R9: reads blocked in echo mode
        vflt = 4'b1001;
        wait_cyc(4);
        frame(fw(1, 4'd7, 16'h0000), 24, r);
        chk("R7 read frame also echoes", r, 24'h000009);
        frame(fw(0, 4'd6, 16'h0000), 24, r);
        chk("R9 no readback after read in echo mode", r, 24'h000009);
        frame(fw(0, 4'd0, 16'h0000), 24, r);
        chk("R9 clearing frame echoes", r, 24'h000009);

        // R8: normal readback
        frame(fw(1, 4'd1, 16'h0000), 24, r);
        chk("R8 read request frame returns zero", r, 24'h0);
        frame(fw(0, 4'd6, 16'h0000), 24, r);
        chk("R8 status returned next frame", r, 24'h000009);
        frame(fw(0, 4'd6, 16'h0000), 24, r);
        chk("R8 pending read consumed", r, 24'h0);
        frame(fw(1, 4'd7, 16'h0000), 24, r);
        frame(fw(1, 4'd0, 16'h0000), 24, r);
        chk("R8 unknown address reads zero", r, 24'h0);
        frame(fw(0, 4'd6, 16'h0000), 24, r);
        chk("R8 control reads echo bit 0", r, 24'h0);

        // R6: short frame discarded
        frame(fw(0, 4'd0, 16'h0001), 23, r);
        frame(fw(0, 4'd6, 16'h0000), 24, r);
        chk("R6 short frame ignored, echo still off", r, 24'h0);
        frame(fw(0, 4'd0, 16'h0001), 25, r);
        frame(fw(0, 4'd6, 16'h0000), 24, r);
        chk("R6 long frame ignored, echo still off", r, 24'h0);
        frame(fw(0, 4'd0, 16'h0001), 24, r);
        frame(fw(0, 4'd6, 16'h0000), 24, r);
        chk("R9 R6 echo set again", r, 24'h000009);

        wait_cyc(4);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule